// File: doc/BRIEF.md
# Dual-Phase Code Group Output Stage

This block sits at the receive edge of a serial link and hands 10-bit line code groups to the next stage over a parallel bus. The groups arrive one per code-group time, and each carries a flag that marks it as a comma (alignment) group. Two complementary output clocks qualify the bus. In the default half-rate mode each output clock runs at half the code-group rate, and successive groups are launched alternately on the rising edges of phase 1 and phase 0. This lets a receiver with slow clocks capture every group on one of the two phases.

When alignment is enabled, a flagged comma is always launched on a rising edge of phase 1. If the comma would otherwise land on phase 0, both clocks hold their level for one extra code-group time. The group just ahead of the comma is discarded, so the comma takes its place on phase 1. A comma-detect pulse follows the phase 0 rising edge after each aligned comma. A static mode input selects a full-rate variant instead. In that mode phase 1 rises once per code-group time and clocks every group, so no stretching is ever needed.

The clocks are modelled as registered levels. The block's own clock `clk` runs at twice the code-group rate. Every second edge after reset is a group boundary, where one input group is sampled and one stored group may be launched. The edges in between are mid-group edges, where the full-rate clocks fall. Mode and alignment enable are straps: they may change only while reset is asserted. Upstream must not send two commas back to back.

Top module: `cg_dual_phase_out`

## Requirements
- R1: While reset is asserted and until the first group boundary, `phase_clk[1]` is 0, `phase_clk[0]` is 1, `grp_out` is 0 and `comma_seen` is 0.
- R2: `phase_clk[0]` is always the complement of `phase_clk[1]`. In half-rate mode (`full_rate`=0) the clocks change only at group boundaries, so each level lasts one code-group time (two `clk` edges) unless it is stretched.
- R3: In half-rate mode with no realignment, groups are launched in arrival order. Each launch is on the next rising edge of phase 1 and phase 0 in turn. A group sampled at boundary b is launched at boundary b+1. The first launch, at boundary 1 on phase 1, carries the reset value 0.
- R4: With `align_en`=1 in half-rate mode, every flagged comma group is launched on a rising edge of `phase_clk[1]`.
- R5: If a flagged comma would be launched on phase 0, both clocks hold their level through one extra code-group time. The group ahead of the comma is discarded, and the comma is launched on the following boundary on phase 1.
- R6: After an aligned comma is launched, `comma_seen` rises together with the next rising edge of `phase_clk[0]`. It stays high for exactly one code-group time: two `clk` edges, which is half a clock period in half-rate mode and one full period in full-rate mode.
- R7: With `align_en`=0, no clock is stretched, no group is discarded, commas may be launched on either phase, and `comma_seen` stays 0. The enable is taken along with each group at its sampling.
- R8: In full-rate mode (`full_rate`=1), `phase_clk[1]` rises at every group boundary and falls at the mid-group edge. Every group is launched on a phase 1 rising edge, in order, and none is discarded.
- R9: `grp_out` changes only together with a rising edge of `phase_clk[1]` or `phase_clk[0]`. It stays stable until the next such edge.
- R10: Inputs are sampled only at group boundaries. The first boundary is the second `clk` edge after reset is released, and every second edge after that is also a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the code-group rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_rate | input | 1 | Strap: 0 selects half-rate dual-phase output, 1 selects full-rate output |
| align_en | input | 1 | Strap: 1 enables comma realignment and the comma-detect pulse |
| grp_in | input | GRP_W (10) | Incoming code group, sampled at group boundaries |
| grp_is_comma | input | 1 | Marks `grp_in` as a comma group |
| grp_out | output | GRP_W (10) | Launched code group |
| phase_clk | output | 2 | Output clocks: bit 1 is phase 1, bit 0 is phase 0 |
| comma_seen | output | 1 | Comma-detect pulse |

## Verification
Several rules are checked on every cycle by the assertions:
- the output word moves only on a rising edge of a phase clock;
- a stretch decision freezes the clocks;
- an aligned comma always lands with phase 1 high;
- the half-rate levels last two edges and the full-rate high lasts one;
- the comma pulse starts as phase 1 falls and then lasts one group time.

The scenarios cover what needs a whole stream to see: the order of launched words, which group is discarded, the exact tick of each launch, and the absence of any pulse or drop when alignment is off. Each scenario sends the same comma-bearing stream, with commas placed so that some must be realigned and one lands on phase 1 naturally, in both modes.

// File: rtl/cgdp_pkg.sv
`timescale 1ns/1ps
package cgdp_pkg;

  typedef enum logic {
    TICK_MID  = 1'b0,
    TICK_EDGE = 1'b1
  } tick_e;

  // A stretch is needed when the group ahead would rise on phase 1,
  // which would push the flagged comma onto phase 0.
  function automatic logic stretch_needed(input logic full_rate,
                                          input logic next_flagged,
                                          input logic ph1_level);
    return !full_rate && next_flagged && !ph1_level;
  endfunction

  // Next level of phase 1.
  function automatic logic ph1_next(input logic full_rate,
                                    input logic at_edge,
                                    input logic stretch,
                                    input logic ph1_level);
    if (full_rate) return at_edge;
    if (at_edge && !stretch) return !ph1_level;
    return ph1_level;
  endfunction

  // Tick on which the comma pulse register may update:
  // boundaries in half-rate mode, mid-group edges in full-rate mode.
  function automatic logic pulse_slot(input logic full_rate,
                                      input logic at_edge);
    return full_rate ? !at_edge : at_edge;
  endfunction

endpackage

// File: rtl/cgdp_tick.sv
`timescale 1ns/1ps
module cgdp_tick (
  input  logic            clk,
  input  logic            rst_n,
  output cgdp_pkg::tick_e tick
);
  logic half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= !half_q;
  end

  assign tick = half_q ? cgdp_pkg::TICK_EDGE : cgdp_pkg::TICK_MID;

endmodule

// File: rtl/cgdp_clkgen.sv
`timescale 1ns/1ps
module cgdp_clkgen (
  input  logic clk,
  input  logic rst_n,
  input  logic full_rate,
  input  logic at_edge,
  input  logic stretch,
  output logic ph1
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph1 <= 1'b0;
    else        ph1 <= cgdp_pkg::ph1_next(full_rate, at_edge, stretch, ph1);
  end

  // R2: a half-rate level lasts at least one code-group time
  assert_half_level_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_rate && $changed(ph1)) |=> $stable(ph1));

  // R8: in full-rate mode phase 1 is high for one edge only
  assert_full_high_one_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_rate && ph1) |=> !ph1);

  // R5: a stretch decision freezes the clocks
  assert_stretch_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stretch |=> $stable(ph1));

endmodule

// File: rtl/cgdp_launch.sv
`timescale 1ns/1ps
module cgdp_launch #(
  parameter int GRP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_rate,
  input  logic             align_en,
  input  logic             at_edge,
  input  logic [GRP_W-1:0] grp_in,
  input  logic             grp_is_comma,
  input  logic             ph1,
  output logic [GRP_W-1:0] word,
  output logic             word_cm,
  output logic             stretch
);
  logic [GRP_W-1:0] stage_q;
  logic             stage_cm_q;
  logic             in_flag;

  assign in_flag = grp_is_comma && align_en;
  assign stretch = at_edge && cgdp_pkg::stretch_needed(full_rate, in_flag, ph1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= '0;
      stage_cm_q <= 1'b0;
      word       <= '0;
      word_cm    <= 1'b0;
    end else if (at_edge) begin
      stage_q    <= grp_in;
      stage_cm_q <= in_flag;
      if (stretch) begin
        word_cm <= 1'b0;          // held word is not announced again
      end else begin
        word    <= stage_q;
        word_cm <= stage_cm_q;
      end
    end
  end

  // R4: an aligned comma launched in half-rate mode lands with phase 1 high
  assert_comma_on_phase1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (at_edge && !full_rate && !stretch && stage_cm_q) |=> ph1);

endmodule

// File: rtl/cgdp_pulse.sv
`timescale 1ns/1ps
module cgdp_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic full_rate,
  input  logic at_edge,
  input  logic stretch,
  input  logic word_cm,
  input  logic ph1,
  output logic pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else if (cgdp_pkg::pulse_slot(full_rate, at_edge)) pulse <= word_cm && !stretch;
  end

  // R6: the pulse starts with the phase 0 rising edge
  assert_pulse_on_phase0_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $fell(ph1));

  // R6: the pulse lasts one code-group time
  assert_pulse_two_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |=> pulse);

  assert_pulse_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && $past(pulse)) |=> !pulse);

endmodule

// File: rtl/cg_dual_phase_out.sv
`timescale 1ns/1ps
module cg_dual_phase_out #(
  parameter int GRP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_rate,
  input  logic             align_en,
  input  logic [GRP_W-1:0] grp_in,
  input  logic             grp_is_comma,
  output logic [GRP_W-1:0] grp_out,
  output logic [1:0]       phase_clk,
  output logic             comma_seen
);
  cgdp_pkg::tick_e tick;
  logic            at_edge;
  logic            ph1;
  logic            stretch;
  logic            word_cm;

  cgdp_tick u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  assign at_edge = (tick == cgdp_pkg::TICK_EDGE);

  cgdp_clkgen u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .full_rate (full_rate),
    .at_edge   (at_edge),
    .stretch   (stretch),
    .ph1       (ph1)
  );

  cgdp_launch #(.GRP_W(GRP_W)) u_launch (
    .clk          (clk),
    .rst_n        (rst_n),
    .full_rate    (full_rate),
    .align_en     (align_en),
    .at_edge      (at_edge),
    .grp_in       (grp_in),
    .grp_is_comma (grp_is_comma),
    .ph1          (ph1),
    .word         (grp_out),
    .word_cm      (word_cm),
    .stretch      (stretch)
  );

  cgdp_pulse u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .full_rate (full_rate),
    .at_edge   (at_edge),
    .stretch   (stretch),
    .word_cm   (word_cm),
    .ph1       (ph1),
    .pulse     (comma_seen)
  );

  assign phase_clk = {ph1, !ph1};

  // R9: the word moves only on a rising edge of one of the phases
  assert_word_moves_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(grp_out) |-> ($rose(phase_clk[1]) || $rose(phase_clk[0])));

endmodule

// File: tb/cg_dual_phase_out_test.sv
`timescale 1ns/1ps
module cg_dual_phase_out_test;
  localparam int W    = 10;
  localparam int MAXS = 128;
  localparam int MAXL = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         full_rate = 1'b0;
  logic         align_en = 1'b0;
  logic [W-1:0] grp_in = '0;
  logic         grp_is_comma = 1'b0;
  logic [W-1:0] grp_out;
  logic [1:0]   phase_clk;
  logic         comma_seen;

  always #2.5 clk = ~clk;

  cg_dual_phase_out #(.GRP_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .full_rate(full_rate), .align_en(align_en),
    .grp_in(grp_in), .grp_is_comma(grp_is_comma), .grp_out(grp_out),
    .phase_clk(phase_clk), .comma_seen(comma_seen)
  );

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] s_w [MAXS];
  logic         s_c1[MAXS];
  logic         s_c0[MAXS];
  logic         s_p [MAXS];
  int           ns;

  logic [W-1:0] st_g[32];
  logic         st_c[32];
  int           st_n;

  logic [W-1:0] e_w[MAXL]; int e_ph[MAXL]; int e_t[MAXL]; logic e_cm[MAXL]; int ne;
  logic [W-1:0] o_w[MAXL]; int o_ph[MAXL]; int o_t[MAXL]; int no;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sample();
    if (ns < MAXS) begin
      s_w[ns] = grp_out; s_c1[ns] = phase_clk[1]; s_c0[ns] = phase_clk[0]; s_p[ns] = comma_seen;
      ns++;
    end
  endtask

  // Reset, then feed st_g/st_c one group per code-group time (two clk edges).
  task automatic run(input bit full, input bit align);
    rst_n = 1'b0; full_rate = full; align_en = align; grp_in = '0; grp_is_comma = 1'b0;
    repeat (3) @(negedge clk);
    ns = 0;
    rst_n = 1'b1;
    for (int g = 0; g < st_n + 3; g++) begin
      sample();
      grp_in       = (g < st_n) ? st_g[g] : '0;
      grp_is_comma = (g < st_n) ? st_c[g] : 1'b0;
      @(negedge clk);
      sample();
      @(negedge clk);
    end
    sample();
  endtask

  function automatic logic [W-1:0] item_g(input int i);
    if (i == 0 || i - 1 >= st_n) return '0;
    return st_g[i-1];
  endfunction

  function automatic logic item_c(input int i);
    if (i == 0 || i - 1 >= st_n) return 1'b0;
    return st_c[i-1];
  endfunction

  // Expected launches from the requirements: boundary b handles item b-1.
  task automatic build_expect(input bit full, input bit align);
    int phase = 1;
    ne = 0;
    for (int b = 1; b <= st_n + 1; b++) begin
      if (!full && align && item_c(b) && phase == 1) continue;  // R5: discard group ahead of comma
      e_w[ne] = item_g(b-1); e_ph[ne] = full ? 1 : phase; e_t[ne] = 2*b;
      e_cm[ne] = item_c(b-1) && align;
      ne++;
      if (!full) phase = 1 - phase;
    end
  endtask

  task automatic extract(input bit full);
    no = 0;
    for (int k = 1; k < ns && k <= 2*(st_n+1); k++) begin
      if (s_c1[k] && !s_c1[k-1]) begin o_w[no] = s_w[k]; o_ph[no] = 1; o_t[no] = k; no++; end
      if (!full && s_c0[k] && !s_c0[k-1]) begin o_w[no] = s_w[k]; o_ph[no] = 0; o_t[no] = k; no++; end
    end
  endtask

  task automatic compare_all(input bit full, input bit align);
    int bad_cmp = 0, bad_stab = 0, bad_pulse = 0, exp_high = 0, obs_high = 0, bad_lvl = 0;
    logic e_p[MAXS];
    build_expect(full, align);
    extract(full);
    check(no == ne, "R3 launch count", no, ne);
    for (int j = 0; j < ne && j < no; j++) begin
      check(o_w[j] == e_w[j], full ? "R8 word order" : "R3 word order", int'(o_w[j]), int'(e_w[j]));
      check(o_ph[j] == e_ph[j], e_cm[j] ? "R4 comma phase" : (full ? "R8 phase" : "R3 phase"), o_ph[j], e_ph[j]);
      check(o_t[j] == e_t[j], align ? "R5 launch tick" : "R7 launch tick", o_t[j], e_t[j]);
    end
    for (int k = 0; k < ns; k++) begin
      if (s_c0[k] != !s_c1[k]) bad_cmp++;
      e_p[k] = 1'b0;
    end
    check(bad_cmp == 0, "R2 complementary phases", bad_cmp, 0);
    for (int k = 1; k < ns; k++) begin
      if (s_w[k] != s_w[k-1] && !(s_c1[k] && !s_c1[k-1]) && !(s_c0[k] && !s_c0[k-1])) bad_stab++;
      if (!full && (k % 2 == 1) && s_c1[k] != s_c1[k-1]) bad_lvl++;
      if (full && (k % 2 == 0) && !s_c1[k]) bad_lvl++;
      if (full && (k % 2 == 1) && s_c1[k]) bad_lvl++;
    end
    check(bad_stab == 0, "R9 word stable between edges", bad_stab, 0);
    check(bad_lvl == 0, full ? "R8 clock shape" : "R2 clock changes only at boundaries", bad_lvl, 0);
    for (int j = 0; j < ne; j++) begin
      if (e_cm[j]) begin
        for (int d = 0; d < 2; d++) begin
          int t = e_t[j] + (full ? 1 : 2) + d;
          if (t < ns) e_p[t] = 1'b1;
        end
      end
    end
    for (int k = 0; k < ns; k++) begin
      if (e_p[k]) exp_high++;
      if (s_p[k]) obs_high++;
      if (e_p[k] != s_p[k]) bad_pulse++;
    end
    check(bad_pulse == 0, align ? "R6 comma pulse timing" : "R7 no comma pulse", bad_pulse, 0);
    check(obs_high == exp_high, align ? "R6 comma pulse length" : "R7 pulse count", obs_high, exp_high);
  endtask

  task automatic load_stream();
    st_n = 14;
    for (int i = 0; i < st_n; i++) begin
      st_g[i] = W'(10'h0A0 + i);
      st_c[i] = 1'b0;
    end
    st_g[2]  = 10'h0F8; st_c[2]  = 1'b1;
    st_g[7]  = 10'h0F9; st_c[7]  = 1'b1;
    st_g[11] = 10'h0FA; st_c[11] = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; full_rate = 1'b0; align_en = 1'b1;
    repeat (2) @(negedge clk);
    check(phase_clk == 2'b01, "R1 clocks in reset", int'(phase_clk), 1);
    check(grp_out == '0, "R1 word in reset", int'(grp_out), 0);
    check(comma_seen == 1'b0, "R1 pulse in reset", int'(comma_seen), 0);
    st_n = 2; st_g[0] = 10'h155; st_c[0] = 1'b0; st_g[1] = 10'h2AA; st_c[1] = 1'b0;
    run(1'b0, 1'b1);
    check(s_c1[1] == 1'b0 && s_w[1] == '0, "R10 no launch at first edge", int'(s_c1[1]), 0);
    check(s_c1[2] == 1'b1, "R10 first boundary at second edge", int'(s_c1[2]), 1);
    check(s_w[4] == 10'h155, "R10 first sampled group launched at boundary 2", int'(s_w[4]), 'h155);
  endtask

  task automatic t_half_plain();
    st_n = 8;
    for (int i = 0; i < st_n; i++) begin st_g[i] = W'(10'h301 + 3*i); st_c[i] = 1'b0; end
    run(1'b0, 1'b1);
    compare_all(1'b0, 1'b1);
  endtask

  task automatic t_half_align();
    load_stream();
    run(1'b0, 1'b1);
    compare_all(1'b0, 1'b1);
    // R5: group 1 (just ahead of the first comma) never reaches the output
    begin
      int seen = 0;
      for (int k = 0; k < ns; k++) if (s_w[k] == st_g[1]) seen++;
      check(seen == 0, "R5 group ahead of comma discarded", seen, 0);
    end
  endtask

  task automatic t_half_noalign();
    load_stream();
    run(1'b0, 1'b0);
    compare_all(1'b0, 1'b0);
  endtask

  task automatic t_full_align();
    load_stream();
    run(1'b1, 1'b1);
    compare_all(1'b1, 1'b1);
  endtask

  task automatic t_full_noalign();
    load_stream();
    run(1'b1, 1'b0);
    compare_all(1'b1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_half_plain();
    t_half_align();
    t_half_noalign();
    t_full_align();
    t_full_noalign();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule